// File: doc/BRIEF.md
# Serial Line Transmitter with Break and Parity Control

This block turns parallel words of 7, 8 or 9 bits into an asynchronous serial frame on a single output line. Each frame has a low start bit, then the data bits least-significant first, then an optional parity bit, then one high stop bit. A bit-rate enable pulse, made elsewhere, sets the pace: the line moves to its next bit only on a clock edge where that pulse is high. A one-word holding buffer sits in front of the shift register. Its empty flag is the signal that the surrounding logic turns into transmit interrupt and transfer requests.

Parity has four kinds: odd, even, forced one and forced zero. A parity bit is added only to 7- and 8-bit frames in normal operation. It is never added to 9-bit frames, or when attention or loopback operation is selected. A break control input pulls the line low at once, for as long as it is held. It abandons any frame already in progress. After release the line stays idle-high for at least one full bit time before a new start bit can go out. Frame settings are captured when a word moves into the shift register, so a frame is never mixed up by a setting that changes part way through.

Top module: `uart_tx_brk`

## Requirements
- R1: While `brk` is high, `txd` is low from the clock edge after `brk` is first sampled high, and it stays low on every following cycle, bit-rate pulses included.
- R2: A frame on `txd` is, one bit per bit-rate pulse: start bit 0, the data bits with bit 0 first, the parity bit if there is one, then stop bit 1. With no word waiting, the line idles at 1.
- R3: `len_sel` picks the data length: 2'b00 gives 7 bits (word bits 6:0), 2'b01 gives 8 bits (bits 7:0), 2'b10 or 2'b11 gives 9 bits (bits 8:0). Word bits above the chosen length are never sent.
- R4: A parity bit is inserted only when `par_en` is 1, `len_sel` selects 7 or 8 bits, and `mode` is 2'b00 (normal). For `mode` 2'b01 (attention), `mode` 2'b10 or 2'b11 (loopback), or 9-bit frames, the stop bit follows the last data bit directly.
- R5: `par_sel` picks the parity value: 2'b00 odd (data bits plus parity hold an odd count of ones), 2'b01 even, 2'b10 always 1, 2'b11 always 0.
- R6: `buf_empty` goes to 1 on the same edge that the held word moves into the shift register, which is the edge where the start bit appears on `txd`. A write into an empty buffer clears `buf_empty` on the next edge.
- R7: A write while the buffer is full is ignored: the held word is not changed, and once it has been sent no second frame follows.
- R8: After `brk` falls, `txd` is 1 from the next edge on, and the first bit-rate pulse after release never starts a frame. The earliest start bit comes on the second pulse.
- R9: After reset, `txd` is 1 and `buf_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-rate enable pulse |
| wr_en | input | 1 | Write strobe into the holding buffer |
| wr_data | input | 9 | Word to send |
| len_sel | input | 2 | Data length: 00 = 7, 01 = 8, 1x = 9 bits |
| par_en | input | 1 | Parity insertion enable |
| par_sel | input | 2 | 00 odd, 01 even, 10 one, 11 zero |
| mode | input | 2 | 00 normal, 01 attention, 1x loopback |
| brk | input | 1 | Break: hold the line low |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding buffer empty flag |

## Verification
The properties assume that `bit_tick` is a single-cycle pulse and that `brk`, `wr_en` and the configuration inputs are stable for a whole clock cycle. They also assume that `brk` is low during reset, because the rule that `txd` moves only on a bit-rate pulse or a break change looks two cycles back. The bench drives every input on the falling clock edge and never holds `bit_tick` high on two cycles in a row. It changes the configuration only while the line is idle, so the captured settings always match the frame the bench expects.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK,
    ST_RECOV
  } tx_state_e;

  localparam logic [1:0] PAR_ODD   = 2'b00;
  localparam logic [1:0] PAR_EVEN  = 2'b01;
  localparam logic [1:0] PAR_ONE   = 2'b10;
  localparam logic [1:0] PAR_ZERO  = 2'b11;

  localparam logic [1:0] LEN_SHORT = 2'b00;
  localparam logic [1:0] LEN_MID   = 2'b01;

  localparam logic [1:0] MODE_NORMAL = 2'b00;

endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic [1:0]        par_sel,
  input  logic [1:0]        mode,
  output logic [CNT_W-1:0]  nbits,
  output logic              par_on,
  output logic              par_bit
);

  logic [DATA_W-1:0] masked;
  logic              ones_odd;

  always_comb begin
    case (len_sel)
      LEN_SHORT: nbits = CNT_W'(DATA_W - 2);
      LEN_MID:   nbits = CNT_W'(DATA_W - 1);
      default:   nbits = CNT_W'(DATA_W);
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked[i] = word[i] & (CNT_W'(i) < nbits);
  end

  assign ones_odd = ^masked;

  // parity only on short/mid frames in normal operation
  assign par_on = par_en && (mode == MODE_NORMAL) && (nbits != CNT_W'(DATA_W));

  always_comb begin
    case (par_sel)
      PAR_ODD:  par_bit = ~ones_odd;
      PAR_EVEN: par_bit = ones_odd;
      PAR_ONE:  par_bit = 1'b1;
      default:  par_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] word,
  output logic              full
);

  logic [DATA_W-1:0] word_q, word_n;
  logic              full_q, full_n;
  logic              accept;

  assign accept = wr_en && !full_q;

  always_comb begin
    word_n = word_q;
    full_n = full_q;
    if (take)   full_n = 1'b0;
    if (accept) begin
      word_n = wr_data;
      full_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (accept) word_q <= word_n;
      full_q <= full_n;
    end
  end

  assign word = word_q;
  assign full = full_q;

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              brk,
  input  logic              full,
  input  logic [DATA_W-1:0] word,
  input  logic [CNT_W-1:0]  nbits,
  input  logic              par_on,
  input  logic              par_bit,
  output logic              take,
  output logic              txd
);

  tx_state_e         state_q, state_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [CNT_W-1:0]  nb_q, nb_n;
  logic              pon_q, pon_n;
  logic              pb_q, pb_n;
  logic              txd_q, txd_n;

  always_comb begin
    state_n = state_q;
    sh_n    = sh_q;
    cnt_n   = cnt_q;
    nb_n    = nb_q;
    pon_n   = pon_q;
    pb_n    = pb_q;
    txd_n   = txd_q;
    take    = 1'b0;
    if (brk) begin
      state_n = ST_BRK;
      txd_n   = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_STOP: begin
          if (bit_tick) begin
            if (full) begin
              take    = 1'b1;
              sh_n    = word;
              nb_n    = nbits;
              pon_n   = par_on;
              pb_n    = par_bit;
              txd_n   = 1'b0;
              state_n = ST_START;
            end else begin
              txd_n   = 1'b1;
              state_n = ST_IDLE;
            end
          end
        end
        ST_START: begin
          if (bit_tick) begin
            txd_n   = sh_q[0];
            sh_n    = sh_q >> 1;
            cnt_n   = nb_q - 1'b1;
            state_n = ST_DATA;
          end
        end
        ST_DATA: begin
          if (bit_tick) begin
            if (cnt_q == '0) begin
              txd_n   = pon_q ? pb_q : 1'b1;
              state_n = pon_q ? ST_PAR : ST_STOP;
            end else begin
              txd_n = sh_q[0];
              sh_n  = sh_q >> 1;
              cnt_n = cnt_q - 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (bit_tick) begin
            txd_n   = 1'b1;
            state_n = ST_STOP;
          end
        end
        ST_BRK: begin
          txd_n   = 1'b1;
          state_n = ST_RECOV;
        end
        ST_RECOV: begin
          if (bit_tick) state_n = ST_IDLE;
        end
        default: begin
          txd_n   = 1'b1;
          state_n = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      nb_q    <= '0;
      pon_q   <= 1'b0;
      pb_q    <= 1'b0;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_n;
      sh_q    <= sh_n;
      cnt_q   <= cnt_n;
      txd_q   <= txd_n;
      if (take) begin
        nb_q  <= nb_n;
        pon_q <= pon_n;
        pb_q  <= pb_n;
      end
    end
  end

  assign txd = txd_q;

endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic [1:0]        par_sel,
  input  logic [1:0]        mode,
  input  logic              brk,
  output logic              txd,
  output logic              buf_empty
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] held;
  logic              full;
  logic              take;
  logic [CNT_W-1:0]  nbits;
  logic              par_on;
  logic              par_bit;

  uart_tx_holdbuf #(.DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .word    (held),
    .full    (full)
  );

  uart_tx_parity #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_par (
    .word    (held),
    .len_sel (len_sel),
    .par_en  (par_en),
    .par_sel (par_sel),
    .mode    (mode),
    .nbits   (nbits),
    .par_on  (par_on),
    .par_bit (par_bit)
  );

  uart_tx_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shf (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .brk      (brk),
    .full     (full),
    .word     (held),
    .nbits    (nbits),
    .par_on   (par_on),
    .par_bit  (par_bit),
    .take     (take),
    .txd      (txd)
  );

  assign buf_empty = !full;

endmodule

// File: rtl/uart_tx_brk_chk.sv
module uart_tx_brk_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic wr_en,
  input logic brk,
  input logic txd,
  input logic buf_empty
);

  AST_BREAK_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !txd);  // R1

  AST_LINE_MOVES_ON_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> ($past(bit_tick) || $past(brk) || $past(brk, 2)));  // R2

  AST_LOAD_SHOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> !txd);  // R6

  AST_LOAD_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(bit_tick));  // R6

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && buf_empty) |=> !buf_empty);  // R6

endmodule

bind uart_tx_brk uart_tx_brk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_tick  (bit_tick),
  .wr_en     (wr_en),
  .brk       (brk),
  .txd       (txd),
  .buf_empty (buf_empty)
);

// File: tb/tb_uart_tx_brk.sv
module tb_uart_tx_brk;

  logic       clk;
  logic       rst_n;
  logic       bit_tick;
  logic       wr_en;
  logic [8:0] wr_data;
  logic [1:0] len_sel;
  logic       par_en;
  logic [1:0] par_sel;
  logic [1:0] mode;
  logic       brk;
  logic       txd;
  logic       buf_empty;

  int checks = 0;
  int fails  = 0;

  uart_tx_brk dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .len_sel   (len_sel),
    .par_en    (par_en),
    .par_sel   (par_sel),
    .mode      (mode),
    .brk       (brk),
    .txd       (txd),
    .buf_empty (buf_empty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {len_sel, par_en, par_sel, mode, data, data bits, parity present, parity value}
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {2'b01, 1'b1, 2'b01, 2'b00, 9'h055, 4'd8, 1'b1, 1'b0},  // R5 even
    {2'b01, 1'b1, 2'b00, 2'b00, 9'h055, 4'd8, 1'b1, 1'b1},  // R5 odd
    {2'b00, 1'b1, 2'b01, 2'b00, 9'h0FE, 4'd7, 1'b1, 1'b0},  // R3 7-bit, bit 7 dropped
    {2'b00, 1'b1, 2'b10, 2'b00, 9'h000, 4'd7, 1'b1, 1'b1},  // R5 forced one
    {2'b01, 1'b1, 2'b11, 2'b00, 9'h0FF, 4'd8, 1'b1, 1'b0},  // R5 forced zero
    {2'b10, 1'b1, 2'b01, 2'b00, 9'h1A5, 4'd9, 1'b0, 1'b0},  // R4 9-bit
    {2'b01, 1'b1, 2'b01, 2'b01, 9'h03C, 4'd8, 1'b0, 1'b0},  // R4 attention
    {2'b01, 1'b1, 2'b01, 2'b10, 9'h081, 4'd8, 1'b0, 1'b0},  // R4 loopback
    {2'b01, 1'b0, 2'b00, 2'b00, 9'h0A5, 4'd8, 1'b0, 1'b0},  // R4 disabled
    {2'b00, 1'b1, 2'b00, 2'b00, 9'h003, 4'd7, 1'b1, 1'b1}   // R5 odd 7-bit
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic write_word(input logic [8:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // runs one frame already queued and checks each bit after its pulse
  task automatic expect_frame(input string req, input logic [8:0] d,
                              input int nb, input logic pp, input logic pv);
    pulse();
    check({req, " R2 start"}, 9'(txd), 9'd0);
    check("R6 empty at load", 9'(buf_empty), 9'd1);
    for (int i = 0; i < nb; i++) begin
      pulse();
      check({req, " R3 data bit"}, 9'(txd), 9'(d[i]));
    end
    if (pp) begin
      pulse();
      check({req, " R5 parity"}, 9'(txd), 9'(pv));
    end
    pulse();
    check({req, " R2 stop"}, 9'(txd), 9'd1);
    pulse();
    check({req, " R2 idle"}, 9'(txd), 9'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    len_sel = 2'b01; par_en = 1'b0; par_sel = 2'b00; mode = 2'b00; brk = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 txd reset", 9'(txd), 9'd1);
    check("R9 empty reset", 9'(buf_empty), 9'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [21:0] e;
      e = VEC[v];
      len_sel = e[21:20]; par_en = e[19]; par_sel = e[18:17]; mode = e[16:15];
      write_word(e[14:6]);
      check("R6 write clears empty", 9'(buf_empty), 9'd0);
      expect_frame("vec", e[14:6], int'(e[5:2]), e[1], e[0]);
    end

    // R7: second write while full is dropped
    len_sel = 2'b01; par_en = 1'b0; mode = 2'b00;
    write_word(9'h00F);
    write_word(9'h0F0);
    check("R7 still full", 9'(buf_empty), 9'd0);
    expect_frame("R7", 9'h00F, 8, 1'b0, 1'b0);
    check("R7 empty after frame", 9'(buf_empty), 9'd1);
    pulse();
    check("R7 no second frame", 9'(txd), 9'd1);

    // R1: break holds the line low across pulses
    @(negedge clk) brk = 1'b1;
    @(negedge clk);
    check("R1 low after break", 9'(txd), 9'd0);
    for (int k = 0; k < 3; k++) begin
      pulse();
      check("R1 low during break", 9'(txd), 9'd0);
    end

    // R8: release, queue a word, first pulse keeps idle, second starts
    @(negedge clk) brk = 1'b0;
    @(negedge clk);
    check("R8 high after release", 9'(txd), 9'd1);
    write_word(9'h0C3);
    pulse();
    check("R8 guard bit stays high", 9'(txd), 9'd1);
    check("R8 word still held", 9'(buf_empty), 9'd0);
    expect_frame("R8", 9'h0C3, 8, 1'b0, 1'b0);

    // R1: break in the middle of a frame forces low at once
    write_word(9'h0FF);
    pulse();
    pulse();
    check("R1 mid-frame data high", 9'(txd), 9'd1);
    @(negedge clk) brk = 1'b1;
    @(negedge clk);
    check("R1 mid-frame break low", 9'(txd), 9'd0);
    @(negedge clk) brk = 1'b0;
    @(negedge clk);
    check("R8 release high", 9'(txd), 9'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule